// File: doc/BRIEF.md
# Masked Watchpoint Comparator

This block is a single debug comparator. It holds a 32-bit compare value, a 4-bit ignore width and a 4-bit function code. It watches two streams. The first is the instruction-address (PC) stream. The second is a data-bus access stream, which carries address, direction, size, fault and first-beat qualifiers. When the selected condition holds, the block raises one of four registered single-cycle pulses:

- a debug (watchpoint) request;
- a trace trigger;
- a PC-sample request;
- a data-sample request.

It also keeps a sticky matched flag, which clears when the function register is read.

The ignore width clears the low address bits on both sides of the compare. A data access matches when any byte it covers falls inside the region that the masked compare value defines.

An instance built with the cycle-compare parameter can compare an external cycle-counter value instead of the PC stream. In that mode the PC-side condition is taken from the counter on every cycle. Software or a debug register file drives the configuration inputs and the read strobe.

Top module: `wp_comparator`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four pulse outputs and `matched` are 0, whatever the inputs are.
- R2: Each pulse is registered. It is high in the single cycle that follows the input cycle that caused it, and low again after that if the condition has gone.
- R3: PC match is `(pc_addr & K) == (cmp_value & K)`, where `K` is all-ones shifted left by `ign_bits`. The low `ign_bits` bits on both sides are therefore ignored.
- R4: A data access covers `2^s` bytes. The size code `ds_size` gives `s`: 0 = byte, 1 = halfword, 2 = word. The access matches when any covered byte matches under R3. This is the R3 compare with a shift of `max(ign_bits, s)`. Size code 3 never matches.
- R5: Function codes 4, 5, 6 and 7 raise `dbg_req` on, respectively:
  - a PC match;
  - a matching read (`ds_write` = 0);
  - a matching write (`ds_write` = 1);
  - a matching read or write.
- R6: Function codes 8 to 11 raise `trc_trig` under the same four conditions as R5. `dbg_req` and `trc_trig` are never high together.
- R7: Code 1 raises `smp_pc` on a PC match. Code 2 raises `smp_data` on any matching access. Code 3 raises `smp_data`, and also `smp_pc`, on any matching access.
- R8: The direction-filtered sampling codes raise outputs on a matching access as follows:
  - code 12: reads, `smp_data` only;
  - code 13: writes, `smp_data` only;
  - code 14: reads, `smp_data` plus `smp_pc`;
  - code 15: writes, `smp_data` plus `smp_pc`.
- R9: `smp_data` is suppressed when `ds_fault` is 1. A PC sample triggered by a data access ignores `ds_fault`, but is raised only when `ds_first` is 1.
- R10: Function code 0 produces no pulse and leaves `matched` unset.
- R11: `matched` rises in the same cycle as any pulse and then holds. It clears in the cycle after a cycle with `flag_rd` = 1. If a new pulse coincides with the clear, the flag stays set.
- R12: With `CYC_CAPABLE` = 1 and `cyc_sel` = 1, the PC-side condition is the R3 compare applied to `cyc_count` on every cycle, and the PC stream is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_value | input | 32 | Compare value |
| ign_bits | input | 4 | Number of low bits ignored |
| func_code | input | 4 | Function code |
| cyc_sel | input | 1 | Compare the cycle counter instead of the PC |
| flag_rd | input | 1 | Function-register read strobe; clears `matched` |
| pc_valid | input | 1 | PC stream valid |
| pc_addr | input | 32 | Instruction address |
| ds_valid | input | 1 | Data access valid |
| ds_addr | input | 32 | Data access address |
| ds_write | input | 1 | 1 = write, 0 = read |
| ds_size | input | 2 | Access size code |
| ds_fault | input | 1 | Access faulted |
| ds_first | input | 1 | First beat of a burst |
| cyc_count | input | 32 | External cycle-counter value |
| dbg_req | output | 1 | Watchpoint debug request pulse |
| trc_trig | output | 1 | Trace trigger pulse |
| smp_pc | output | 1 | PC sample request pulse |
| smp_data | output | 1 | Data sample request pulse |
| matched | output | 1 | Sticky matched flag |

## Verification
The bound checker watches several rules on every cycle:
- debug and trigger pulses are exclusive, and each follows a function code of its own class;
- a data sample never follows a faulted or idle access;
- function code 0 stays silent;
- `matched` is high with every pulse and falls only after a read strobe.

The correctness of the mask arithmetic and the byte-span overlap for each access size can only be shown by the bench's scenarios. The same holds for the exact function decode, the fault and first-beat qualifiers on sampling, the sticky hold across idle cycles and the cycle-counter mode.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [3:0] {
        FN_OFF      = 4'd0,
        FN_SPC      = 4'd1,
        FN_SDAT     = 4'd2,
        FN_SBOTH    = 4'd3,
        FN_WP_PC    = 4'd4,
        FN_WP_RD    = 4'd5,
        FN_WP_WR    = 4'd6,
        FN_WP_RW    = 4'd7,
        FN_TR_PC    = 4'd8,
        FN_TR_RD    = 4'd9,
        FN_TR_WR    = 4'd10,
        FN_TR_RW    = 4'd11,
        FN_SDAT_RD  = 4'd12,
        FN_SDAT_WR  = 4'd13,
        FN_SBOTH_RD = 4'd14,
        FN_SBOTH_WR = 4'd15
    } wp_func_e;

    // Class of a function code, taken from its upper two bits
    localparam logic [1:0] CLS_SAMPLE = 2'b00;
    localparam logic [1:0] CLS_WATCH  = 2'b01;
    localparam logic [1:0] CLS_TRIG   = 2'b10;
    localparam logic [1:0] CLS_SDIR   = 2'b11;

    localparam logic [1:0] SZ_BAD = 2'b11;

    typedef struct packed {
        logic dbg;
        logic trig;
        logic spc;
        logic sdat;
    } wp_pulse_t;

    typedef struct packed {
        wp_pulse_t pulse;
        logic      matched;
    } wp_state_t;

endpackage

// File: rtl/wp_span_match.sv
// Masked compare. The shift is the larger of the ignore width and the
// log2 byte size of the access. Both sides are then aligned
// power-of-two blocks, so they overlap exactly when they agree above
// that shift.
module wp_span_match #(
    parameter int AW  = 32,
    parameter int IGW = 4,
    parameter int SZW = 2
) (
    input  logic [AW-1:0]  addr,
    input  logic [AW-1:0]  cmp,
    input  logic [IGW-1:0] ign,
    input  logic [SZW-1:0] szlog,
    output logic           hit
);
    localparam int SHW = (IGW > SZW) ? IGW : SZW;

    logic [SHW-1:0] ign_w;
    logic [SHW-1:0] sz_w;
    logic [SHW-1:0] shamt;
    logic [AW-1:0]  keep;

    always_comb begin
        ign_w = SHW'(ign);
        sz_w  = SHW'(szlog);
        shamt = (sz_w > ign_w) ? sz_w : ign_w;
        keep  = {AW{1'b1}} << shamt;
        hit   = ((addr ^ cmp) & keep) == '0;
    end
endmodule

// File: rtl/wp_func_decode.sv
module wp_func_decode
    import wp_pkg::*;
(
    input  logic [3:0] code,
    input  logic       pc_ev,
    input  logic       rd_ev,
    input  logic       wr_ev,
    input  logic       ds_fault,
    input  logic       ds_first,
    output wp_pulse_t  pl
);
    logic sel_ev;
    logic dat_any;
    logic dir_ev;

    always_comb begin
        pl      = '0;
        dat_any = rd_ev | wr_ev;
        dir_ev  = code[0] ? wr_ev : rd_ev;
        unique case (code[1:0])
            2'd0:    sel_ev = pc_ev;
            2'd1:    sel_ev = rd_ev;
            2'd2:    sel_ev = wr_ev;
            default: sel_ev = dat_any;
        endcase
        unique case (code[3:2])
            CLS_WATCH: pl.dbg  = sel_ev;
            CLS_TRIG:  pl.trig = sel_ev;
            CLS_SDIR: begin
                pl.sdat = dir_ev & ~ds_fault;
                pl.spc  = code[1] & dir_ev & ds_first;
            end
            default: begin
                unique case (code[1:0])
                    2'd1: pl.spc = pc_ev;
                    2'd2: pl.sdat = dat_any & ~ds_fault;
                    2'd3: begin
                        pl.sdat = dat_any & ~ds_fault;
                        pl.spc  = dat_any & ds_first;
                    end
                    default: pl = '0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/wp_comparator.sv
module wp_comparator
    import wp_pkg::*;
#(
    parameter int AW          = 32,
    parameter int IGW         = 4,
    parameter bit CYC_CAPABLE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  cmp_value,
    input  logic [IGW-1:0] ign_bits,
    input  logic [3:0]     func_code,
    input  logic           cyc_sel,
    input  logic           flag_rd,
    input  logic           pc_valid,
    input  logic [AW-1:0]  pc_addr,
    input  logic           ds_valid,
    input  logic [AW-1:0]  ds_addr,
    input  logic           ds_write,
    input  logic [1:0]     ds_size,
    input  logic           ds_fault,
    input  logic           ds_first,
    input  logic [AW-1:0]  cyc_count,
    output logic           dbg_req,
    output logic           trc_trig,
    output logic           smp_pc,
    output logic           smp_data,
    output logic           matched
);
    wp_state_t st_d, st_q;
    wp_pulse_t dec;

    logic pc_hit, ds_hit, cyc_hit, cyc_mode;
    logic pc_ev, rd_ev, wr_ev, size_ok;

    wp_span_match #(.AW(AW), .IGW(IGW), .SZW(2)) u_pc_cmp (
        .addr(pc_addr), .cmp(cmp_value), .ign(ign_bits),
        .szlog(2'd0), .hit(pc_hit)
    );

    wp_span_match #(.AW(AW), .IGW(IGW), .SZW(2)) u_ds_cmp (
        .addr(ds_addr), .cmp(cmp_value), .ign(ign_bits),
        .szlog(ds_size), .hit(ds_hit)
    );

    generate
        if (CYC_CAPABLE) begin : g_cyc
            wp_span_match #(.AW(AW), .IGW(IGW), .SZW(2)) u_cyc_cmp (
                .addr(cyc_count), .cmp(cmp_value), .ign(ign_bits),
                .szlog(2'd0), .hit(cyc_hit)
            );
            assign cyc_mode = cyc_sel;
        end else begin : g_nocyc
            assign cyc_hit  = 1'b0;
            assign cyc_mode = 1'b0;
        end
    endgenerate

    always_comb begin
        size_ok = (ds_size != SZ_BAD);
        pc_ev   = cyc_mode ? cyc_hit : (pc_valid & pc_hit);
        rd_ev   = ds_valid & ~ds_write & ds_hit & size_ok;
        wr_ev   = ds_valid &  ds_write & ds_hit & size_ok;
    end

    wp_func_decode u_dec (
        .code(func_code), .pc_ev(pc_ev), .rd_ev(rd_ev), .wr_ev(wr_ev),
        .ds_fault(ds_fault), .ds_first(ds_first), .pl(dec)
    );

    always_comb begin
        st_d.pulse   = dec;
        st_d.matched = (|dec) | (st_q.matched & ~flag_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_req  = st_q.pulse.dbg;
    assign trc_trig = st_q.pulse.trig;
    assign smp_pc   = st_q.pulse.spc;
    assign smp_data = st_q.pulse.sdat;
    assign matched  = st_q.matched;
endmodule

// File: rtl/wp_comparator_chk.sv
module wp_comparator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] func_code,
    input logic       flag_rd,
    input logic       ds_valid,
    input logic       ds_fault,
    input logic       dbg_req,
    input logic       trc_trig,
    input logic       smp_pc,
    input logic       smp_data,
    input logic       matched
);
    logic any_pulse;
    assign any_pulse = dbg_req | trc_trig | smp_pc | smp_data;

    assert_dbg_trig_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_req && trc_trig));

    assert_dbg_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> $past(func_code[3:2] == 2'b01));

    assert_trig_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trc_trig |-> $past(func_code[3:2] == 2'b10));

    assert_no_faulted_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_data |-> $past(ds_valid && !ds_fault));

    assert_off_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(func_code == 4'd0) |-> !any_pulse);

    assert_flag_with_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |-> matched);

    assert_flag_clear_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(matched) |-> $past(flag_rd));
endmodule

bind wp_comparator wp_comparator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .func_code(func_code), .flag_rd(flag_rd),
    .ds_valid(ds_valid), .ds_fault(ds_fault), .dbg_req(dbg_req),
    .trc_trig(trc_trig), .smp_pc(smp_pc), .smp_data(smp_data),
    .matched(matched)
);

// File: tb/wp_comparator_test.sv
`timescale 1ns/1ps
module wp_comparator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cmp_value = '0;
    logic [3:0]  ign_bits = '0;
    logic [3:0]  func_code = '0;
    logic        cyc_sel = 1'b0;
    logic        flag_rd = 1'b0;
    logic        pc_valid = 1'b0;
    logic [31:0] pc_addr = '0;
    logic        ds_valid = 1'b0;
    logic [31:0] ds_addr = '0;
    logic        ds_write = 1'b0;
    logic [1:0]  ds_size = '0;
    logic        ds_fault = 1'b0;
    logic        ds_first = 1'b0;
    logic [31:0] cyc_count = '0;
    logic        dbg_req, trc_trig, smp_pc, smp_data, matched;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wp_comparator uut (
        .clk(clk), .rst_n(rst_n), .cmp_value(cmp_value), .ign_bits(ign_bits),
        .func_code(func_code), .cyc_sel(cyc_sel), .flag_rd(flag_rd),
        .pc_valid(pc_valid), .pc_addr(pc_addr), .ds_valid(ds_valid),
        .ds_addr(ds_addr), .ds_write(ds_write), .ds_size(ds_size),
        .ds_fault(ds_fault), .ds_first(ds_first), .cyc_count(cyc_count),
        .dbg_req(dbg_req), .trc_trig(trc_trig), .smp_pc(smp_pc),
        .smp_data(smp_data), .matched(matched)
    );

    // The exp field is ordered {dbg, trig, spc, sdat}
    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  fn;
        logic [3:0]  ign;
        logic [31:0] cmp;
        logic        pcv;
        logic [31:0] pc;
        logic        dsv;
        logic [31:0] da;
        logic        wr;
        logic [1:0]  sz;
        logic        flt;
        logic        fst;
        logic [3:0]  exp;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{8'd5, 4'd4, 4'd0, 32'h1000, 1'b1, 32'h1000, 1'b0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 4'b1000}, // R5
        '{8'd3, 4'd4, 4'd0, 32'h1000, 1'b1, 32'h1004, 1'b0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 4'b0000}, // R3
        '{8'd3, 4'd4, 4'd4, 32'h1000, 1'b1, 32'h100C, 1'b0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 4'b1000}, // R3
        '{8'd3, 4'd4, 4'd4, 32'h1000, 1'b1, 32'h1010, 1'b0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 4'b0000}, // R3
        '{8'd5, 4'd5, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b1000}, // R5
        '{8'd5, 4'd5, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b1, 4'b0000}, // R5
        '{8'd5, 4'd6, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b1, 4'b1000}, // R5
        '{8'd5, 4'd7, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b1, 4'b1000}, // R5
        '{8'd6, 4'd9, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0100}, // R6
        '{8'd6, 4'd8, 4'd0, 32'h1000, 1'b1, 32'h1000, 1'b0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 4'b0100}, // R6
        '{8'd6, 4'd10,4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0000}, // R6
        '{8'd4, 4'd5, 4'd0, 32'h3,    1'b0, 32'h0,    1'b1, 32'h0,    1'b0, 2'd2, 1'b0, 1'b1, 4'b1000}, // R4
        '{8'd4, 4'd5, 4'd0, 32'h3,    1'b0, 32'h0,    1'b1, 32'h0,    1'b0, 2'd0, 1'b0, 1'b1, 4'b0000}, // R4
        '{8'd4, 4'd5, 4'd0, 32'h3,    1'b0, 32'h0,    1'b1, 32'h2,    1'b0, 2'd1, 1'b0, 1'b1, 4'b1000}, // R4
        '{8'd4, 4'd5, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd3, 1'b0, 1'b1, 4'b0000}, // R4
        '{8'd7, 4'd2, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0001}, // R7
        '{8'd9, 4'd2, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0000}, // R9
        '{8'd9, 4'd3, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0010}, // R9
        '{8'd9, 4'd3, 4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0001}, // R9
        '{8'd7, 4'd1, 4'd0, 32'h1000, 1'b1, 32'h1000, 1'b0, 32'h0,    1'b0, 2'd0, 1'b0, 1'b0, 4'b0010}, // R7
        '{8'd8, 4'd12,4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b1, 4'b0000}, // R8
        '{8'd8, 4'd12,4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0001}, // R8
        '{8'd8, 4'd13,4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b1, 2'd2, 1'b0, 1'b1, 4'b0001}, // R8
        '{8'd8, 4'd14,4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0011}, // R8
        '{8'd8, 4'd15,4'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0000}, // R8
        '{8'd10,4'd0, 4'd0, 32'h1000, 1'b1, 32'h1000, 1'b1, 32'h1000, 1'b0, 2'd2, 1'b0, 1'b1, 4'b0000}  // R10
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pc_valid = 1'b0; ds_valid = 1'b0; ds_write = 1'b0; ds_size = 2'd0;
        ds_fault = 1'b0; ds_first = 1'b0; cyc_sel = 1'b0; flag_rd = 1'b0;
    endtask

    function automatic logic [3:0] outs();
        return {dbg_req, trc_trig, smp_pc, smp_data};
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: a matching PC during reset produces nothing
        func_code = 4'd4; cmp_value = 32'h1000; pc_valid = 1'b1; pc_addr = 32'h1000;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {27'd0, outs(), matched}, 32'd0);
        rst_n = 1'b1;
        idle_inputs();
        @(negedge clk);
        chk("R1 outputs after reset", {27'd0, outs(), matched}, 32'd0);

        // Table walk, with flag_rd held so that matched tracks each vector (R11)
        for (int i = 0; i < NV; i++) begin
            func_code = VECS[i].fn;  ign_bits = VECS[i].ign; cmp_value = VECS[i].cmp;
            pc_valid  = VECS[i].pcv; pc_addr  = VECS[i].pc;
            ds_valid  = VECS[i].dsv; ds_addr  = VECS[i].da;  ds_write = VECS[i].wr;
            ds_size   = VECS[i].sz;  ds_fault = VECS[i].flt; ds_first = VECS[i].fst;
            flag_rd   = 1'b1;
            @(negedge clk);
            chk($sformatf("R%0d vector %0d pulses", VECS[i].req, i), {28'd0, outs()}, {28'd0, VECS[i].exp});
            chk($sformatf("R11 vector %0d matched", i), {31'd0, matched}, {31'd0, |VECS[i].exp});
        end
        idle_inputs();
        func_code = 4'd0; ign_bits = 4'd0;
        @(negedge clk);

        // R2: one-cycle cause gives a one-cycle pulse; R11 sticky hold and clear
        func_code = 4'd4; cmp_value = 32'h2000; pc_valid = 1'b1; pc_addr = 32'h2000;
        @(negedge clk);
        chk("R2 pulse high", {31'd0, dbg_req}, 32'd1);
        pc_valid = 1'b0;
        @(negedge clk);
        chk("R2 pulse single cycle", {31'd0, dbg_req}, 32'd0);
        chk("R11 flag holds", {31'd0, matched}, 32'd1);
        @(negedge clk);
        chk("R11 flag holds idle", {31'd0, matched}, 32'd1);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
        chk("R11 flag cleared by read", {31'd0, matched}, 32'd0);
        // R11: a read coinciding with a new pulse leaves the flag set
        pc_valid = 1'b1; flag_rd = 1'b1;
        @(negedge clk);
        pc_valid = 1'b0; flag_rd = 1'b0;
        chk("R11 set wins over read", {31'd0, matched}, 32'd1);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;

        // R12: cycle-counter compare
        cyc_sel = 1'b1; func_code = 4'd4; cmp_value = 32'h40; ign_bits = 4'd0;
        cyc_count = 32'h40; pc_valid = 1'b0;
        @(negedge clk);
        chk("R12 counter match", {31'd0, dbg_req}, 32'd1);
        cyc_count = 32'h41; pc_valid = 1'b1; pc_addr = 32'h40;
        @(negedge clk);
        chk("R12 PC stream ignored", {31'd0, dbg_req}, 32'd0);
        pc_valid = 1'b0; ign_bits = 4'd4; cyc_count = 32'h4F;
        @(negedge clk);
        chk("R12 counter masked match", {31'd0, dbg_req}, 32'd1);
        idle_inputs();
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule